// File: doc/BRIEF.md
# Daisy-Chainable Serial DAC Word Interface

This block is the digital front end of a 16-bit digital-to-analog converter. It receives a 16-bit word over a three-wire synchronous serial link (frame select, serial clock, data in). It holds the word in an input latch, and a load strobe moves the word into the DAC latch that drives the converter. Every serial input is brought into a single system clock domain by synchroniser flops. Serial clock edges are then found by edge detection in that domain.

When the chain enable is high, the far end of the shift register is driven onto a serial output. Several devices can then share one link: each device passes on whatever it receives 16 serial clocks later. A coding select chooses between straight binary and twos-complement input words. The DAC latch always holds the straight-binary (offset) form, so twos-complement words reach it with the top bit inverted. A clear strobe sets the converter to the code for zero volts under the current coding.

Top module: `dac_serial_front`

## Requirements
- R1: Serial clock edges are acted on only while `frame_n` is low. Rising serial clock edges that occur while `frame_n` is high leave the shift register unchanged.
- R2: The serial output changes only after a falling serial clock edge. It then takes the most significant bit of the shift register, so a bit presented at `sdi` appears at `sdo` for the downstream device 16 serial clocks later.
- R3: While `load_n` and `clr_n` are both high, `dac_code` keeps its value. Driving `load_n` low copies the input latch into the DAC latch within 6 system clocks.
- R4: While `load_n` is held low, a completed frame reaches `dac_code` with no separate load pulse.
- R5: With `twos_sel` = 0 the word is passed to `dac_code` unchanged (straight binary). With `twos_sel` = 1 the word is read as twos complement and bit 15 is inverted on transfer, so 0x0005 gives 0x8005 and 0xFFFF gives 0x7FFF.
- R6: While `clr_n` is low, `dac_code` becomes 0x0000 if `twos_sel` = 0 and 0x8000 if `twos_sel` = 1. Clear takes priority over load.
- R7: A frame that ends (`frame_n` rising) after fewer than 16 rising serial clock edges leaves the input latch unchanged.
- R8: While `chain_en` is low, `sdo` is held low.
- R9: After reset, `dac_code` is 0x0000, `sdo` is 0 and the input latch holds 0x0000.
- R10: Data is sampled on rising serial clock edges, most significant bit first. If a frame has more than 16 edges, the last 16 bits received are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Frame select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in |
| chain_en | input | 1 | Enables the serial pass-through output |
| load_n | input | 1 | Load strobe, active low (level-transparent) |
| clr_n | input | 1 | Clear strobe, active low |
| twos_sel | input | 1 | Coding select: 0 binary, 1 twos complement |
| sdo | output | 1 | Serial data out to the next device |
| dac_code | output | 16 | DAC latch contents, straight-binary form |

## Verification
A wrong bit counter or a missed edge in the shift register cannot be seen at `dac_code` until the next load strobe. The same fault shows up much sooner on `sdo` when chaining is on: the word that comes out 16 clocks later is shifted or corrupted. For this reason the scoreboard compares both the DAC latch after each load and the bit stream captured from `sdo`. A wrong coding or clear state shows up on `dac_code` within a few system clocks of the strobe.

// File: rtl/dac_front_pkg.sv
// Package: shared constants and types for the serial DAC front end.
// Assumes: all consumers are clocked in a single system clock domain.
package dac_front_pkg;

    typedef enum logic {
        CODE_BINARY = 1'b0,
        CODE_TWOS   = 1'b1
    } coding_e;

    // Index of each asynchronous input inside the synchroniser bank
    localparam int IX_FRAME = 0;
    localparam int IX_SCLK  = 1;
    localparam int IX_SDI   = 2;
    localparam int IX_CHAIN = 3;
    localparam int IX_LOAD  = 4;
    localparam int IX_CLR   = 5;
    localparam int IX_TWOS  = 6;
    localparam int N_ASYNC  = 7;

endpackage

// File: rtl/sync_bank.sv
// Module: sync_bank
// Does:    brings N asynchronous bits into the clk domain through a chain
//          of STAGES flops per bit.
// Assumes: each bit is quasi-static relative to clk; no bus coherency.
module sync_bank #(
    parameter int          N       = 7,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift each bit one flop further along the chain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= RST_VAL;
                else if (s == 0)
                    stage_q[s] <= d;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/shift_core.sv
// Module: shift_core
// Does:    detects serial clock edges, shifts data MSB first on rising
//          edges inside a frame, counts bits and flags the frame end. It
//          also drives the chain output on falling edges.
// Assumes: inputs are already synchronised to clk.
module shift_core #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              frm_n_s,
    input  logic              sdi_s,
    input  logic              chain_s,
    output logic [WORD_W-1:0] shreg,
    output logic              word_ok,
    output logic              frm_end,
    output logic              sdo
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic             sck_d, frm_d;
    logic             sck_rise, sck_fall, frm_fall;
    logic [CNT_W-1:0] bit_cnt;

    // Remember previous sampled levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            frm_d <= 1'b1;
        end else begin
            sck_d <= sck_s;
            frm_d <= frm_n_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign frm_fall = ~frm_n_s & frm_d;
    assign frm_end  = frm_n_s & ~frm_d;

    // Shift data in on rising edges, only while the frame is active
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (!frm_n_s && sck_rise)
            shreg <= {shreg[WORD_W-2:0], sdi_s};
    end

    // Count bits in the current frame, saturating at the word width
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_cnt <= '0;
        else if (frm_fall)
            bit_cnt <= '0;
        else if (!frm_n_s && sck_rise && bit_cnt != CNT_W'(WORD_W))
            bit_cnt <= bit_cnt + 1'b1;
    end

    assign word_ok = (bit_cnt == CNT_W'(WORD_W));

    // Drive the chain output on falling edges, or hold it low when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !chain_s)
            sdo <= 1'b0;
        else if (sck_fall)
            sdo <= shreg[WORD_W-1];
    end
endmodule

// File: rtl/latch_stage.sv
// Module: latch_stage
// Does:    keeps the input latch and the DAC latch. It applies the coding
//          conversion on transfer and forces the zero-volt code on clear.
// Assumes: strobes are synchronised, active low; clear wins over load.
module latch_stage
    import dac_front_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_end,
    input  logic              word_ok,
    input  logic [WORD_W-1:0] shreg,
    input  logic              load_n_s,
    input  logic              clr_n_s,
    input  coding_e           coding,
    output logic [WORD_W-1:0] in_word,
    output logic [WORD_W-1:0] dac_code
);
    localparam logic [WORD_W-1:0] SIGN_BIT = {1'b1, {(WORD_W-1){1'b0}}};

    logic [WORD_W-1:0] conv_word, zero_code;

    assign conv_word = (coding == CODE_TWOS) ? (in_word ^ SIGN_BIT) : in_word;
    assign zero_code = (coding == CODE_TWOS) ? SIGN_BIT : '0;

    // Capture a complete word at frame end
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_word <= '0;
        else if (frm_end && word_ok)
            in_word <= shreg;
    end

    // Update the DAC latch: clear first, then level-transparent load
    always_ff @(posedge clk) begin
        if (!rst_n)
            dac_code <= '0;
        else if (!clr_n_s)
            dac_code <= zero_code;
        else if (!load_n_s)
            dac_code <= conv_word;
    end
endmodule

// File: rtl/dac_serial_front.sv
// Module: dac_serial_front (top)
// Does:    serial word receiver for a 16-bit DAC with chain output, load
//          and clear strobes, and a binary or twos-complement coding choice.
// Assumes: serial clock half period spans several system clocks.
module dac_serial_front
    import dac_front_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              chain_en,
    input  logic              load_n,
    input  logic              clr_n,
    input  logic              twos_sel,
    output logic              sdo,
    output logic [WORD_W-1:0] dac_code
);
    localparam logic [N_ASYNC-1:0] IDLE_LVL =
        N_ASYNC'((1 << IX_FRAME) | (1 << IX_LOAD) | (1 << IX_CLR));

    logic [N_ASYNC-1:0] raw_in, syn;
    logic [WORD_W-1:0]  shreg, in_word;
    logic               word_ok, frm_end;
    coding_e            coding;

    always_comb begin
        raw_in           = '0;
        raw_in[IX_FRAME] = frame_n;
        raw_in[IX_SCLK]  = sclk;
        raw_in[IX_SDI]   = sdi;
        raw_in[IX_CHAIN] = chain_en;
        raw_in[IX_LOAD]  = load_n;
        raw_in[IX_CLR]   = clr_n;
        raw_in[IX_TWOS]  = twos_sel;
    end

    assign coding = coding_e'(syn[IX_TWOS]);

    sync_bank #(.N(N_ASYNC), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn)
    );

    shift_core #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (syn[IX_SCLK]),
        .frm_n_s (syn[IX_FRAME]),
        .sdi_s   (syn[IX_SDI]),
        .chain_s (syn[IX_CHAIN]),
        .shreg   (shreg),
        .word_ok (word_ok),
        .frm_end (frm_end),
        .sdo     (sdo)
    );

    latch_stage #(.WORD_W(WORD_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_end  (frm_end),
        .word_ok  (word_ok),
        .shreg    (shreg),
        .load_n_s (syn[IX_LOAD]),
        .clr_n_s  (syn[IX_CLR]),
        .coding   (coding),
        .in_word  (in_word),
        .dac_code (dac_code)
    );
endmodule

// File: rtl/dac_serial_front_chk.sv
// Module: dac_serial_front_chk
// Does:    property checks on the serial DAC front end, bound to the top.
// Assumes: signals are sampled on the system clock; reset is active low.
module dac_serial_front_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [6:0]        syn,
    input logic [WORD_W-1:0] shreg,
    input logic [WORD_W-1:0] in_word,
    input logic              frm_end,
    input logic              word_ok,
    input logic              sdo,
    input logic [WORD_W-1:0] dac_code
);
    import dac_front_pkg::*;
    localparam logic [WORD_W-1:0] MID = {1'b1, {(WORD_W-1){1'b0}}};

    a_r1_no_shift_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        syn[IX_FRAME] |=> $stable(shreg));

    a_r8_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !syn[IX_CHAIN] |=> !sdo);

    a_r6_clear_binary: assert property (@(posedge clk) disable iff (!rst_n)
        (!syn[IX_CLR] && !syn[IX_TWOS]) |=> (dac_code == '0));

    a_r6_clear_twos: assert property (@(posedge clk) disable iff (!rst_n)
        (!syn[IX_CLR] && syn[IX_TWOS]) |=> (dac_code == MID));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (syn[IX_CLR] && syn[IX_LOAD]) |=> $stable(dac_code));

    a_r7_short_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_end && !word_ok) |=> $stable(in_word));
endmodule

bind dac_serial_front dac_serial_front_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .syn      (syn),
    .shreg    (shreg),
    .in_word  (in_word),
    .frm_end  (frm_end),
    .word_ok  (word_ok),
    .sdo      (sdo),
    .dac_code (dac_code)
);

// File: tb/dac_serial_front_tb_top.sv
// Bench: scoreboard style. Driver tasks push expected items into a queue
// and a monitor at the falling clock edge pops and compares them.
module dac_serial_front_tb_top;
    localparam int HP = 6;  // serial half period in system clocks

    typedef struct {
        int          kind;  // 0: dac_code, 1: captured sdo word
        logic [15:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic        chain_en = 1'b0, load_n = 1'b1, clr_n = 1'b1, twos_sel = 1'b0;
    logic        sdo;
    logic [15:0] dac_code;
    logic [15:0] cap = '0;
    item_t       sb_q[$];
    int          n_vec = 0, n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    dac_serial_front dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sclk(sclk), .sdi(sdi),
        .chain_en(chain_en), .load_n(load_n), .clr_n(clr_n),
        .twos_sel(twos_sel), .sdo(sdo), .dac_code(dac_code)
    );

    // Monitor: pop and compare expected items
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = sb_q.pop_front();
            act = (it.kind == 0) ? dac_code : cap;
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: kind %0d actual %h expected %h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic expect_item(input int kind, input logic [15:0] v, input string req);
        item_t it;
        it.kind = kind; it.exp = v; it.req = req;
        sb_q.push_back(it);
        wait_clk(2);
    endtask

    // One serial clock; the downstream capture samples sdo at the rising edge
    task automatic clock_bit(input logic b);
        sdi = b;
        wait_clk(HP);
        sclk = 1'b1;
        cap = {cap[14:0], sdo};
        wait_clk(HP);
        sclk = 1'b0;
    endtask

    task automatic send_frame(input logic [31:0] w, input int n);
        frame_n = 1'b0;
        wait_clk(HP);
        for (int i = n - 1; i >= 0; i--) clock_bit(w[i]);
        wait_clk(HP);
        frame_n = 1'b1;
        wait_clk(2 * HP);
    endtask

    task automatic pulse_load();
        load_n = 1'b0; wait_clk(4);
        load_n = 1'b1; wait_clk(8);
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        expect_item(0, 16'h0000, "R9 reset code");
        expect_item(1, 16'h0000, "R9 reset sdo");
        pulse_load();
        expect_item(0, 16'h0000, "R9 reset input latch");

        send_frame(32'h1234, 16);
        expect_item(0, 16'h0000, "R3 held before load");
        pulse_load();
        expect_item(0, 16'h1234, "R10 binary word loaded");

        send_frame(32'hABCD, 16);
        wait_clk(10);
        expect_item(0, 16'h1234, "R3 hold with load high");
        pulse_load();
        expect_item(0, 16'hABCD, "R5 binary pass");

        twos_sel = 1'b1;
        send_frame(32'h0005, 16);
        pulse_load();
        expect_item(0, 16'h8005, "R5 twos positive");
        send_frame(32'hFFFF, 16);
        pulse_load();
        expect_item(0, 16'h7FFF, "R5 twos minus one");

        clr_n = 1'b0; wait_clk(8);
        expect_item(0, 16'h8000, "R6 clear twos");
        load_n = 1'b0; wait_clk(8);
        expect_item(0, 16'h8000, "R6 clear over load");
        load_n = 1'b1; twos_sel = 1'b0; wait_clk(8);
        expect_item(0, 16'h0000, "R6 clear binary");
        clr_n = 1'b1; wait_clk(4);

        send_frame(32'h1111, 16);
        pulse_load();
        send_frame(32'h5555, 10);
        pulse_load();
        expect_item(0, 16'h1111, "R7 short frame ignored");

        load_n = 1'b0; wait_clk(8);
        send_frame(32'h2222, 16);
        wait_clk(8);
        expect_item(0, 16'h2222, "R4 transparent load");
        load_n = 1'b1; wait_clk(8);

        chain_en = 1'b0; wait_clk(4);
        send_frame(32'hFFFF, 16);
        expect_item(1, 16'h0000, "R8 sdo low when disabled");

        chain_en = 1'b1; wait_clk(4);
        send_frame({16'hC0DE, 16'h9A5F}, 32);
        expect_item(1, 16'hC0DE, "R2 chained word out");
        pulse_load();
        expect_item(0, 16'h9A5F, "R10 last 16 bits kept");

        send_frame(32'h3C3C, 16);
        sdi = 1'b1;
        for (int k = 0; k < 16; k++) clock_bit(1'b1);
        send_frame(32'h0000, 16);
        expect_item(1, 16'h3C3C, "R1 clocks outside frame ignored");

        wait_clk(4);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        wait_clk(150000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule